// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block computes a page-wide Hamming code in the background while data words move between a host and a NAND flash device. It observes a tapped word stream and counts a word only while the NAND chip-select is asserted. It folds every counted word into a set of row and column parity pairs. The same accumulation runs for programming and for read-back. After a program, the host reads the finished code from `ecc_code` and stores it in the spare area. After a read, the host drives the stored code onto `ecc_stored`. The engine then classifies the difference between the stored code and the recomputed code.

The row parity indexes the word within the page and the column parity indexes the bit within the word. Each index bit has an even half and an odd half. A single flipped data bit therefore makes every pair differ, and the odd halves of the difference give the word address and bit position. A difference with exactly one set bit means the stored code itself was damaged. Any other non-zero difference is reported as uncorrectable.

The word port is a tap with a valid/ready pair. `s_ready` is held high and the engine never applies back-pressure. A word is counted when `s_valid`, `s_ready` and `nand_cs` are all high and the page is not yet complete. Words that arrive at any other time are dropped without effect. A one-cycle `ecc_clr` pulse clears the engine at the start of each page.

Top module: `nand_ecc_top`

## Requirements
- R1: After reset, `ecc_code` is zero, `page_done` is low and all error outputs are zero.
- R2: The cycle after `ecc_clr` is sampled high, `ecc_code` is zero and `page_done` is low, even partway through a page.
- R3: `s_ready` is always high. A word updates the code only when `s_valid` and `nand_cs` are both high. Cycles with either signal low leave `ecc_code` unchanged.
- R4: The code encoding works as follows. For word address w (the count of words taken since the last clear) and each set data bit at index i, the engine toggles `ecc_code` bit 2*b+i[b] for b = 0..3. It also toggles bit 8+2*a+w[a] for a = 0..11. The update is visible the cycle after the word is taken.
- R5: When `bus_wide` = 0, only `s_data[7:0]` contributes to the code. When `bus_wide` = 1, all 16 bits contribute.
- R6: `page_sel` values 0, 1, 2 and 3 select 512, 1024, 2048 and 4096 bytes. A page holds that many words at 8 bits, or half as many at 16 bits. `page_done` rises the cycle after the last word of the page is taken.
- R7: While `page_done` is high, further words change neither `ecc_code` nor `page_done` until the next clear.
- R8: With `page_done` high and `ecc_code` equal to `ecc_stored`, all error outputs are zero.
- R9: With `page_done` high, suppose every even/odd pair of the difference `ecc_code ^ ecc_stored` differs within itself. Then `err_any` and `err_fixable` are high. `err_word` equals difference bits 9,11,...,31 and `err_bit` equals bits 1,3,5,7.
- R10: With `page_done` high and exactly one set bit in the difference, `err_any` and `err_in_ecc` are high and `err_fixable` is low.
- R11: With `page_done` high and any other non-zero difference, only `err_any` is high.
- R12: While `page_done` is low, all error outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clr | input | 1 | Clears code, count and done flag |
| nand_cs | input | 1 | NAND chip-select, active high |
| bus_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| page_sel | input | 2 | Page size code |
| s_valid | input | 1 | Word strobe on the tapped bus |
| s_ready | output | 1 | Always high |
| s_data | input | 16 | Tapped data word |
| ecc_stored | input | 32 | Code read from the spare area |
| ecc_code | output | 32 | Accumulated code |
| page_done | output | 1 | Page complete, status valid |
| err_any | output | 1 | Any mismatch |
| err_fixable | output | 1 | Single-bit data error |
| err_in_ecc | output | 1 | Single-bit error in stored code |
| err_word | output | 12 | Faulty word address |
| err_bit | output | 4 | Faulty bit index |

## Verification
The bench targets the page boundary. It runs the last word of a 4096-word page and pushes extra words after completion. An engine with an off-by-one count would raise `page_done` a word early or late. An engine that ignored the done state would keep folding words into a finished code. The bench also flips data bits in the high byte while in 8-bit mode. A design that failed to mask the unused lane would report a spurious error there. It corrupts two bits of one word, one bit of the stored code, and a single bit at high word addresses. These cases catch a classifier that confuses an ECC-area hit with a data error, or that takes the location from the wrong half of each pair. Clears are issued mid-page, and words are sent with the chip-select low, to check that neither kind of cycle leaks into the code.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BIDX_W = 4;
  localparam int unsigned ECC_W  = 2 * (ADDR_W + BIDX_W);
  localparam int unsigned CNT_W  = ADDR_W + 1;

  typedef struct packed {
    logic              any;
    logic              fixable;
    logic              in_ecc;
    logic [ADDR_W-1:0] word;
    logic [BIDX_W-1:0] bidx;
  } ecc_stat_t;
endpackage

// File: rtl/nand_ecc_cnt.sv
module nand_ecc_cnt
  import nand_ecc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          beat,
  input  logic          wide,
  input  logic [1:0]    sel,
  output logic          take,
  output logic [AW-1:0] waddr,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // bytes = 512 << sel; a 16-bit bus halves the word count
  always_comb begin
    limit = wide ? (CW'(256) << sel) : (CW'(512) << sel);
  end

  assign take  = beat & ~done;
  assign waddr = cnt_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == limit) done <= 1'b1;
    end
  end

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done && $stable(cnt_q));
  a_r6_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(take));
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BIDX_W,
  localparam int unsigned EW = 2 * (AW + BW),
  localparam int unsigned HALF = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          wide,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] data,
  output logic [EW-1:0] ecc
);
  logic [EW-1:0] ecc_q;
  logic [EW-1:0] ecc_d;
  logic [DW-1:0] lane;

  assign lane = wide ? data : {{(DW-HALF){1'b0}}, data[HALF-1:0]};

  always_comb begin
    ecc_d = ecc_q;
    for (int i = 0; i < DW; i++) begin
      if (lane[i]) begin
        for (int b = 0; b < BW; b++)
          ecc_d[2*b + ((i >> b) & 1)] = ~ecc_d[2*b + ((i >> b) & 1)];
        for (int a = 0; a < AW; a++)
          ecc_d[2*(BW+a) + int'(waddr[a])] = ~ecc_d[2*(BW+a) + int'(waddr[a])];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ecc_q <= '0;
    else if (clr)    ecc_q <= '0;
    else if (take)   ecc_q <= ecc_d;
  end

  assign ecc = ecc_q;

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> $stable(ecc_q));
  a_r2_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ecc_q == '0));
endmodule

// File: rtl/nand_ecc_syn.sv
module nand_ecc_syn
  import nand_ecc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BIDX_W,
  localparam int unsigned NP = AW + BW,
  localparam int unsigned EW = 2 * NP
) (
  input  logic          done,
  input  logic [EW-1:0] calc,
  input  logic [EW-1:0] stored,
  output ecc_stat_t     stat
);
  logic [EW-1:0] syn;
  logic [NP-1:0] pair_diff;
  logic [NP-1:0] odd;
  logic          all_pairs;
  logic          single;

  assign syn = calc ^ stored;

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign pair_diff[k] = syn[2*k] ^ syn[2*k+1];
    assign odd[k]       = syn[2*k+1];
  end

  assign all_pairs = &pair_diff;
  assign single    = ($countones(syn) == 1);

  always_comb begin
    stat         = '0;
    stat.any     = done && (syn != '0);
    stat.fixable = done && all_pairs;
    stat.in_ecc  = done && !all_pairs && single;
    if (stat.fixable) begin
      stat.bidx = odd[BW-1:0];
      stat.word = odd[NP-1:BW];
    end
  end

  always_comb begin
    a_r10_exclusive: assert (!(stat.fixable && stat.in_ecc));
    a_r9_implies_any: assert (!(stat.fixable || stat.in_ecc) || stat.any);
  end
endmodule

// File: rtl/nand_ecc_top.sv
module nand_ecc_top
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BIDX_W,
  localparam int unsigned EW = 2 * (AW + BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ecc_clr,
  input  logic          nand_cs,
  input  logic          bus_wide,
  input  logic [1:0]    page_sel,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic [EW-1:0] ecc_stored,
  output logic [EW-1:0] ecc_code,
  output logic          page_done,
  output logic          err_any,
  output logic          err_fixable,
  output logic          err_in_ecc,
  output logic [AW-1:0] err_word,
  output logic [BW-1:0] err_bit
);
  logic          take;
  logic [AW-1:0] waddr;
  ecc_stat_t     stat;

  assign s_ready = 1'b1;

  nand_ecc_cnt #(.AW(AW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(ecc_clr),
    .beat(s_valid & s_ready & nand_cs),
    .wide(bus_wide), .sel(page_sel),
    .take(take), .waddr(waddr), .done(page_done)
  );

  nand_ecc_acc #(.DW(DW), .AW(AW), .BW(BW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .take(take),
    .wide(bus_wide), .waddr(waddr), .data(s_data), .ecc(ecc_code)
  );

  nand_ecc_syn #(.AW(AW), .BW(BW)) u_syn (
    .done(page_done), .calc(ecc_code), .stored(ecc_stored), .stat(stat)
  );

  assign err_any     = stat.any;
  assign err_fixable = stat.fixable;
  assign err_in_ecc  = stat.in_ecc;
  assign err_word    = stat.word;
  assign err_bit     = stat.bidx;

  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !page_done |-> !(err_any || err_fixable || err_in_ecc));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (page_done && !ecc_clr) |=> $stable(ecc_code));
endmodule

// File: tb/sim_nand_ecc_top.sv
`timescale 1ns/1ps
module sim_nand_ecc_top;
  logic clk = 0;
  logic rst_n = 0;
  logic ecc_clr = 0, nand_cs = 0, bus_wide = 0, s_valid = 0;
  logic [1:0] page_sel = 0;
  logic [15:0] s_data = 0;
  logic [31:0] ecc_stored = 0;
  logic s_ready, page_done, err_any, err_fixable, err_in_ecc;
  logic [31:0] ecc_code;
  logic [11:0] err_word;
  logic [3:0] err_bit;

  always #5 clk = ~clk;

  nand_ecc_top u0 (.*);

  int n_chk = 0, n_bad = 0;
  string cur = "R1";
  logic [31:0] m_ecc = 0;
  int m_cnt = 0;
  bit m_done = 0;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int limit();
    return (bus_wide ? 256 : 512) << page_sel;
  endfunction

  function automatic logic [15:0] gen(int seed, int w);
    return 16'((w * 40503 + seed * 977) ^ (w >> 3) ^ (seed << 9));
  endfunction

  // behavioural status from the model
  task automatic compare();
    logic [31:0] s; int pairs; bit e, f, x; int wd, bt;
    s = m_ecc ^ ecc_stored;
    pairs = 0; wd = 0; bt = 0;
    for (int k = 0; k < 16; k++) if (s[2*k] != s[2*k+1]) pairs++;
    for (int b = 0; b < 4; b++) bt += s[2*b+1] << b;
    for (int a = 0; a < 12; a++) wd += s[8+2*a+1] << a;
    e = m_done && (s != 0);
    f = m_done && (pairs == 16);
    x = m_done && !f && ($countones(s) == 1);
    if (!f) begin wd = 0; bt = 0; end
    chk({cur, " R4 code"}, ecc_code == m_ecc, ecc_code, m_ecc);
    chk({cur, " R6 done"}, page_done == m_done, page_done, m_done);
    chk({cur, " R3 ready"}, s_ready == 1'b1, s_ready, 1);
    chk({cur, " R11 any"}, err_any == e, err_any, e);
    chk({cur, " R9 fixable"}, err_fixable == f, err_fixable, f);
    chk({cur, " R10 in_ecc"}, err_in_ecc == x, err_in_ecc, x);
    chk({cur, " R9 loc"}, {err_word, err_bit} == 16'(wd * 16 + bt), {err_word, err_bit}, wd * 16 + bt);
  endtask

  task automatic beat(input bit v, input bit c, input logic [15:0] d);
    s_valid = v; nand_cs = c; s_data = d; ecc_clr = 0;
    @(posedge clk);
    if (v && c && !m_done) begin
      for (int i = 0; i < (bus_wide ? 16 : 8); i++) if (d[i]) begin
        for (int b = 0; b < 4; b++) m_ecc[2*b + ((i >> b) & 1)] ^= 1'b1;
        for (int a = 0; a < 12; a++) m_ecc[8 + 2*a + ((m_cnt >> a) & 1)] ^= 1'b1;
      end
      m_cnt++;
      if (m_cnt == limit()) m_done = 1;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic clear();
    s_valid = 0; ecc_clr = 1;
    @(posedge clk);
    m_ecc = 0; m_cnt = 0; m_done = 0;
    @(negedge clk);
    ecc_clr = 0;
    compare();
  endtask

  task automatic run_page(input int seed, input int fw, input logic [15:0] mask);
    for (int w = 0; w < limit(); w++) begin
      if (w % 7 == 3) begin beat(0, 1, 16'hffff); beat(1, 0, 16'hffff); end
      beat(1, 1, gen(seed, w) ^ ((w == fw) ? mask : 16'h0));
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] good;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = "R1";
    chk("R1 reset code", ecc_code == 0, ecc_code, 0);
    chk("R1 reset done", page_done == 0, page_done, 0);
    compare();

    cur = "R6 R4 8b/512";
    bus_wide = 0; page_sel = 0; clear();
    run_page(1, -1, 0);
    good = m_ecc;
    chk("R6 done after 512 words", page_done == 1, page_done, 1);

    cur = "R8"; ecc_stored = good; clear(); run_page(1, -1, 0);
    chk("R8 clean page", err_any == 0, err_any, 0);

    cur = "R9"; clear(); run_page(1, 100, 16'h0020);
    chk("R9 word", err_word == 100, err_word, 100);
    chk("R9 bit", err_bit == 5, err_bit, 5);

    cur = "R7";
    for (int k = 0; k < 5; k++) beat(1, 1, 16'h5a5a);

    cur = "R11"; clear(); run_page(1, 7, 16'h0011);
    chk("R11 uncorrectable", err_any && !err_fixable && !err_in_ecc, {err_any, err_fixable, err_in_ecc}, 3'b100);

    cur = "R10"; ecc_stored = good ^ 32'h0000_0200; clear(); run_page(1, -1, 0);
    chk("R10 ecc area", err_in_ecc == 1, err_in_ecc, 1);

    cur = "R5 8b high lane"; ecc_stored = good; clear(); run_page(1, 40, 16'h0100);
    chk("R5 high byte ignored", err_any == 0, err_any, 0);

    cur = "R5 16b/1024"; bus_wide = 1; page_sel = 1; clear(); run_page(2, -1, 0);
    good = m_ecc; ecc_stored = good;
    clear(); run_page(2, 300, 16'h8000);
    chk("R5 wide bit", err_bit == 15, err_bit, 15);
    chk("R5 wide word", err_word == 300, err_word, 300);

    cur = "R2"; clear();
    for (int k = 0; k < 10; k++) beat(1, 1, gen(3, k));
    clear();
    chk("R2 mid-page clear", ecc_code == 0 && !page_done, ecc_code, 0);

    cur = "R6 8b/4096"; bus_wide = 0; page_sel = 3; clear(); run_page(4, -1, 0);
    good = m_ecc; ecc_stored = good;
    clear(); run_page(4, 4095, 16'h0080);
    chk("R6 last word", err_word == 4095 && err_bit == 7, {err_word, err_bit}, {12'd4095, 4'd7});

    cur = "R12"; clear();
    chk("R12 quiet before done", !err_any && !err_fixable && !err_in_ecc, err_any, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule